// File: doc/BRIEF.md
# Taken-Branch Event Counter

This block is a 16-bit performance counter that sits at one fixed address in the I/O part of the memory map. The datapath bumps it by one each time a conditional branch is taken, and software can overwrite it with an ordinary store. Software usually clears it by storing zero at the start of a measured region. At the end of the region it reads the count back with a normal load, which the block serves from its read port.

Each load-phase cycle the block chooses one of three update modes. HOLD keeps the count and applies when neither source is active. STORE loads the memory data register and applies when a write hits the counter's address. INCR adds one and applies on a taken branch. The block never holds a mode from one cycle to the next, so any mode can follow any other. HOLD goes to STORE on an address-matched write and to INCR on a taken branch, and any mode returns to HOLD when both sources are quiet. A write to the address and a taken branch in the same cycle should never happen. If they do, STORE wins. The count changes only at a rising clock edge with the load strobe high.

Top module: `taken_branch_counter`

## Requirements
- R1: While `rst_n` is low, the count is forced to 0x0000 at each rising edge.
- R2: With `ld_strobe`=1, `mio_en`=1, `mar`=0xFE08 and `mem_write`=1, the count takes the value of `mdr` at the next edge. This includes storing 0 to clear it.
- R3: A read of 0xFE08 (`mem_write`=0) returns the current count on `count_q` and leaves it unchanged. So does a write to any other address, or any access with `mio_en`=0.
- R4: A taken branch adds one to the count at the next edge. A taken branch is `ld_strobe`=1, `br_en`=1 and `ucond`=2'b10.
- R5: With `br_en`=0, or with `ucond` equal to 2'b00, 2'b01 or 2'b11, a branch does not change the count.
- R6: Incrementing from 0xFFFF gives 0x0000.
- R7: If a store to 0xFE08 and a taken branch come in the same cycle, the count takes `mdr`.
- R8: With `ld_strobe`=0, the count does not change, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ucond | input | 2 | Branch-condition field of the current microinstruction; 2'b10 marks a conditional branch |
| br_en | input | 1 | Branch condition evaluated true |
| mio_en | input | 1 | Memory or I/O access enabled this cycle |
| mar | input | 16 | Access address |
| mem_write | input | 1 | 1 = write access, 0 = read access |
| mdr | input | 16 | Store data |
| ld_strobe | input | 1 | Load phase; register updates are allowed only when high |
| count_q | output | 16 | Current counter value (read port) |

## Verification
The assertions assume that every input is at a known value at each rising edge once reset is released. They also assume that the inputs do not change near that edge. The store-priority assertion takes into account that the store and the taken branch may coincide. The bench changes inputs only on the falling clock edge and drives a defined value on every input in every cycle. It includes directed cycles where both sources are active, so the priority rule is exercised rather than avoided.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 16;
    localparam int COND_W = 2;

    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_INCR  = 2'd1,
        UPD_STORE = 2'd2
    } upd_mode_t;
endpackage

// File: rtl/tbc_addr_decode.sv
module tbc_addr_decode #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] MAP_ADDR = 16'hFE08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mio_en,
    input  logic [ADDR_W-1:0] mar,
    input  logic              mem_write,
    output logic              store_hit
);
    logic addr_match;

    always_comb begin
        addr_match = (mar == MAP_ADDR);
        store_hit  = mio_en && addr_match && mem_write;
    end

    // A read access may never be taken for a store
    AST_READ_NOT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_write |-> !store_hit); // R3
    AST_DISABLED_NOT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        !mio_en |-> !store_hit); // R3
endmodule

// File: rtl/tbc_branch_detect.sv
module tbc_branch_detect #(
    parameter int                COND_W     = 2,
    parameter logic [COND_W-1:0] TAKEN_CODE = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COND_W-1:0] ucond,
    input  logic              br_en,
    output logic              br_taken
);
    always_comb begin
        br_taken = br_en && (ucond == TAKEN_CODE);
    end

    AST_OTHER_COND_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (ucond != TAKEN_CODE) |-> !br_taken); // R5
    AST_NO_ENABLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !br_en |-> !br_taken); // R5
endmodule

// File: rtl/tbc_load_ctrl.sv
module tbc_load_ctrl
    import tbc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      store_hit,
    input  logic      br_taken,
    output upd_mode_t mode
);
    // Store is ranked above increment so a coincident pair stays deterministic
    always_comb begin
        unique case ({store_hit, br_taken})
            2'b00:   mode = UPD_HOLD;
            2'b01:   mode = UPD_INCR;
            2'b10:   mode = UPD_STORE;
            default: mode = UPD_STORE;
        endcase
    end

    AST_STORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        store_hit |-> (mode == UPD_STORE)); // R7
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!store_hit && !br_taken) |-> (mode == UPD_HOLD)); // R3
endmodule

// File: rtl/tbc_count_reg.sv
module tbc_count_reg
    import tbc_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_strobe,
    input  upd_mode_t     mode,
    input  logic [DW-1:0] store_data,
    output logic [DW-1:0] count_q
);
    logic [DW-1:0] count_nxt;
    logic          load_en;

    always_comb begin
        load_en = ld_strobe && (mode != UPD_HOLD);
        unique case (mode)
            UPD_INCR:  count_nxt = count_q + DW'(1);
            UPD_STORE: count_nxt = store_data;
            default:   count_nxt = count_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_en) begin
            count_q <= count_nxt;
        end
    end

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_strobe && (mode != UPD_HOLD)) |=> $stable(count_q)); // R8
    AST_INCR_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_strobe && mode == UPD_INCR) |=> (count_q == DW'($past(count_q) + DW'(1)))); // R6
    AST_STORE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_strobe && mode == UPD_STORE) |=> (count_q == $past(store_data))); // R2
endmodule

// File: rtl/taken_branch_counter.sv
module taken_branch_counter
    import tbc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MAP_ADDR   = 16'hFE08,
    parameter logic [COND_W-1:0] TAKEN_CODE = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COND_W-1:0] ucond,
    input  logic              br_en,
    input  logic              mio_en,
    input  logic [ADDR_W-1:0] mar,
    input  logic              mem_write,
    input  logic [DATA_W-1:0] mdr,
    input  logic              ld_strobe,
    output logic [DATA_W-1:0] count_q
);
    logic      store_hit;
    logic      br_taken;
    upd_mode_t mode;

    tbc_addr_decode #(.ADDR_W(ADDR_W), .MAP_ADDR(MAP_ADDR)) u_dec (
        .clk(clk), .rst_n(rst_n), .mio_en(mio_en), .mar(mar),
        .mem_write(mem_write), .store_hit(store_hit)
    );

    tbc_branch_detect #(.COND_W(COND_W), .TAKEN_CODE(TAKEN_CODE)) u_br (
        .clk(clk), .rst_n(rst_n), .ucond(ucond), .br_en(br_en), .br_taken(br_taken)
    );

    tbc_load_ctrl u_ctl (
        .clk(clk), .rst_n(rst_n), .store_hit(store_hit), .br_taken(br_taken), .mode(mode)
    );

    tbc_count_reg #(.DW(DATA_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .ld_strobe(ld_strobe), .mode(mode),
        .store_data(mdr), .count_q(count_q)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (count_q == '0)); // R1
    AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mio_en && mar == MAP_ADDR && !mem_write && !(br_en && ucond == TAKEN_CODE))
        |=> $stable(count_q)); // R3
endmodule

// File: tb/taken_branch_counter_bench.sv
module taken_branch_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ucond = 2'b00;
    logic        br_en = 1'b0;
    logic        mio_en = 1'b0;
    logic [15:0] mar = 16'h0000;
    logic        mem_write = 1'b0;
    logic [15:0] mdr = 16'h0000;
    logic        ld_strobe = 1'b0;
    logic [15:0] count_q;

    int checks = 0;
    int errors = 0;
    int model = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    taken_branch_counter u_taken_branch_counter (
        .clk(clk), .rst_n(rst_n), .ucond(ucond), .br_en(br_en), .mio_en(mio_en),
        .mar(mar), .mem_write(mem_write), .mdr(mdr), .ld_strobe(ld_strobe),
        .count_q(count_q)
    );

    // Reference: evaluated at each rising edge with the values driven before it
    always @(posedge clk) begin
        if (!rst_n) model = 0;
        else if (ld_strobe) begin
            if (mio_en && mar == 16'hFE08 && mem_write) model = int'(mdr);
            else if (br_en && ucond == 2'b10) model = (model + 1) % 65536;
        end
    end

    task automatic compare(input string tag);
        checks++;
        if (int'(count_q) != model) begin
            errors++;
            $display("FAIL %s count_q=%h expected=%h", tag, count_q, model[15:0]);
        end
    endtask

    task automatic cyc(input bit rn, input bit stb, input bit mio, input logic [15:0] a,
                       input bit wr, input logic [15:0] d, input logic [1:0] c,
                       input bit be, input string tag);
        @(negedge clk);
        rst_n = rn; ld_strobe = stb; mio_en = mio; mar = a; mem_write = wr;
        mdr = d; ucond = c; br_en = be;
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(0, 1, 1, 16'hFE08, 1, 16'hAAAA, 2'b10, 1, "R1 reset");
        cyc(0, 0, 0, 16'h0000, 0, 16'h0000, 2'b00, 0, "R1 reset held");
        cyc(1, 1, 1, 16'hFE08, 1, 16'h1234, 2'b00, 0, "R2 store");
        cyc(1, 1, 1, 16'hFE08, 0, 16'h5555, 2'b00, 0, "R3 read keeps");
        cyc(1, 1, 1, 16'hFE0A, 1, 16'h7777, 2'b00, 0, "R3 other address");
        cyc(1, 1, 0, 16'hFE08, 1, 16'h7777, 2'b00, 0, "R3 io disabled");
        cyc(1, 1, 0, 16'h0000, 0, 16'h0000, 2'b10, 1, "R4 taken");
        cyc(1, 1, 0, 16'h0000, 0, 16'h0000, 2'b10, 1, "R4 taken again");
        cyc(1, 1, 0, 16'h0000, 0, 16'h0000, 2'b00, 1, "R5 cond 00");
        cyc(1, 1, 0, 16'h0000, 0, 16'h0000, 2'b01, 1, "R5 cond 01");
        cyc(1, 1, 0, 16'h0000, 0, 16'h0000, 2'b11, 1, "R5 cond 11");
        cyc(1, 1, 0, 16'h0000, 0, 16'h0000, 2'b10, 0, "R5 not enabled");
        cyc(1, 0, 0, 16'h0000, 0, 16'h0000, 2'b10, 1, "R8 branch no strobe");
        cyc(1, 0, 1, 16'hFE08, 1, 16'h9999, 2'b00, 0, "R8 store no strobe");
        cyc(1, 1, 1, 16'hFE08, 1, 16'hFFFF, 2'b00, 0, "R2 store max");
        cyc(1, 1, 0, 16'h0000, 0, 16'h0000, 2'b10, 1, "R6 wrap");
        cyc(1, 1, 1, 16'hFE08, 1, 16'h4321, 2'b10, 1, "R7 store wins");
        cyc(1, 1, 1, 16'hFE08, 1, 16'h0000, 2'b00, 0, "R2 clear");
        cyc(1, 1, 0, 16'h0000, 0, 16'h0000, 2'b10, 1, "R4 after clear");
        for (int i = 0; i < 400; i++) begin
            bit        s = ($urandom % 4) != 0;
            bit        m = ($urandom % 3) != 0;
            bit        w = $urandom % 2;
            bit        b = $urandom % 2;
            logic [1:0]  c = 2'($urandom);
            logic [15:0] a = (($urandom % 2) != 0) ? 16'hFE08 : 16'($urandom);
            logic [15:0] d = 16'($urandom);
            cyc(1, s, m, a, w, d, c, b, "R2 R4 R7 R8 mixed");
        end
        cyc(0, 1, 0, 16'h0000, 0, 16'h0000, 2'b10, 1, "R1 late reset");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule